// File: doc/BRIEF.md
# Block-Coded Scan Fill Expander

This block turns a compact stream of per-block codes into the serial bit stream that feeds one scan chain. A scan load is cut into blocks of `BLK_LEN` consecutive scan bits. For each block a two-bit code says how to fill it:

- a fixed 0;
- a fixed 1;
- bits drawn from an on-chip pseudo-random register.

Blocks whose care bits all agree are filled with a constant. They cause no shift transitions inside the block, and they consume no pseudo-random bits. Only the mixed blocks need their care bits encoded into seeds.

A test controller presents codes on a valid/ready handshake. It loads seeds whenever a new mixed segment needs one, and it requests bits one at a time with `shift_req`. Each accepted request yields one registered output bit with a valid strobe. A done strobe marks the final bit of every scan load of `BLKS_PER_LOAD` blocks.

Top module: `blk_fill_expander`

## Requirements
- R1: After reset, `scan_valid` and `load_done` are 0, `code_ready` is 1, the block counter is zero and the pseudo-random register holds `LFSR_INIT` (default 16'h0001).
- R2: A block with code 2'b00 emits `BLK_LEN` bits of value 0.
- R3: A block with code 2'b01 emits `BLK_LEN` bits of value 1.
- R4: A block with code 2'b10 or 2'b11 emits, for each bit, bit 0 of the register state, after which the state steps as `next = (state >> 1) ^ (state[0] ? LFSR_TAPS : 0)` (default taps 16'hB400).
- R5: The register keeps its state on every cycle that emits no bit of a code-2'b1x block, so constant blocks consume no pseudo-random bits.
- R6: A cycle with `seed_load` high replaces the register state with `seed_data` on the next edge, and takes priority over a step in that same cycle.
- R7: `scan_valid` rises exactly one cycle after each edge where `shift_req` is high while a block is in progress. `shift_req` with no block in progress produces no output bit.
- R8: `code_ready` is high when no block is in progress, or when `shift_req` is high on a block's final bit. A code accepted on that final-bit edge starts emitting with no gap cycle. Otherwise `code_ready` is low during a block.
- R9: `load_done` is high together with the `scan_valid` of the last bit of every `BLKS_PER_LOAD`-th block counted from reset, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | A block code is offered |
| code | input | 2 | Block code: 00 zero fill, 01 one fill, 1x pseudo-random |
| code_ready | output | 1 | The offered code is taken at the next edge |
| seed_load | input | 1 | Load `seed_data` into the pseudo-random register |
| seed_data | input | LFSR_W | Seed value |
| shift_req | input | 1 | Request the next scan bit |
| scan_bit | output | 1 | Scan-in bit |
| scan_valid | output | 1 | `scan_bit` is valid this cycle |
| load_done | output | 1 | This bit is the last of a scan load |

## Verification
The bench interleaves constant blocks between pseudo-random ones and compares the output against a model that steps only on mixed-block bits. A design that advanced the register during constant fill would produce a shifted random sequence and fail. A code is offered on a block's final bit to catch designs that insert a bubble or drop the code at the block boundary. A shift request with no block in progress catches designs that emit spurious bits. A seed load between blocks must restart the sequence exactly, and the done strobe is checked on every third block across several loads.

// File: rtl/blk_fill_expander.sv
module blk_fill_expander #(
  parameter int BLK_LEN = 4,
  parameter int BLKS_PER_LOAD = 3,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_INIT = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [1:0]        code,
  output logic              code_ready,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_data,
  input  logic              shift_req,
  output logic              scan_bit,
  output logic              scan_valid,
  output logic              load_done
);
  localparam int BW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam int LW = (BLKS_PER_LOAD > 1) ? $clog2(BLKS_PER_LOAD) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(BLK_LEN - 1);
  localparam logic [LW-1:0] LAST_BLK = LW'(BLKS_PER_LOAD - 1);

  logic              busy;
  logic [BW-1:0]     bit_cnt;
  logic [LW-1:0]     blk_cnt;
  logic [1:0]        blk_code;
  logic [LFSR_W-1:0] lfsr;

  wire last_bit  = (bit_cnt == LAST_BIT);
  wire last_blk  = (blk_cnt == LAST_BLK);
  wire shift     = busy && shift_req;
  wire from_lfsr = blk_code[1];
  wire take      = code_valid && code_ready;
  wire [LFSR_W-1:0] lfsr_nxt = (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);

  assign code_ready = !busy || (shift && last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      bit_cnt    <= '0;
      blk_cnt    <= '0;
      blk_code   <= 2'b00;
      lfsr       <= LFSR_INIT;
      scan_bit   <= 1'b0;
      scan_valid <= 1'b0;
      load_done  <= 1'b0;
    end else begin
      scan_valid <= shift;
      load_done  <= shift && last_bit && last_blk;
      if (shift) begin
        scan_bit <= from_lfsr ? lfsr[0] : blk_code[0];
        bit_cnt  <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit)
          blk_cnt <= last_blk ? '0 : blk_cnt + 1'b1;
      end
      if (take) begin
        busy     <= 1'b1;
        blk_code <= code;
      end else if (shift && last_bit) begin
        busy <= 1'b0;
      end
      if (seed_load)
        lfsr <= seed_data;
      else if (shift && from_lfsr)
        lfsr <= lfsr_nxt;
    end
  end
endmodule

// File: rtl/blk_fill_expander_chk.sv
module blk_fill_expander_chk #(
  parameter int BLK_LEN = 4,
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              code_ready,
  input logic              seed_load,
  input logic [LFSR_W-1:0] seed_data,
  input logic              shift_req,
  input logic              scan_bit,
  input logic              scan_valid,
  input logic              load_done,
  input logic              busy,
  input logic [((BLK_LEN > 1) ? $clog2(BLK_LEN) : 1)-1:0] bit_cnt,
  input logic [1:0]        blk_code,
  input logic [LFSR_W-1:0] lfsr
);
  localparam int BW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(BLK_LEN - 1);

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid && $past(blk_code) == 2'b00 |-> !scan_bit); // R2
  AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid && $past(blk_code) == 2'b01 |-> scan_bit); // R3
  AST_RAND_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid && $past(blk_code[1]) |-> scan_bit == $past(lfsr[0])); // R4
  AST_RAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(seed_load && rst_n) && !$past(busy && shift_req && blk_code[1]) |-> lfsr == $past(lfsr)); // R5
  AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seed_load && rst_n) |-> lfsr == $past(seed_data)); // R6
  AST_NO_IDLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |-> $past(busy && shift_req)); // R7
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(shift_req && bit_cnt == LAST_BIT) |-> !code_ready); // R8
  AST_DONE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> scan_valid); // R9
endmodule

bind blk_fill_expander blk_fill_expander_chk #(.BLK_LEN(BLK_LEN), .LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_ready(code_ready), .seed_load(seed_load),
  .seed_data(seed_data), .shift_req(shift_req), .scan_bit(scan_bit),
  .scan_valid(scan_valid), .load_done(load_done), .busy(busy),
  .bit_cnt(bit_cnt), .blk_code(blk_code), .lfsr(lfsr)
);

// File: tb/sim_blk_fill_expander.sv
`timescale 1ns/1ps
module sim_blk_fill_expander;
  localparam int B = 4;
  localparam int BPL = 3;
  localparam int W = 16;
  localparam logic [W-1:0] TAPS = 16'hB400;
  localparam int NV = 12;
  localparam logic [1:0] CODES [NV] = '{2'b00, 2'b10, 2'b01, 2'b10, 2'b11, 2'b00,
                                        2'b10, 2'b10, 2'b01, 2'b11, 2'b00, 2'b10};

  logic clk = 0, rst_n = 0, code_valid = 0, seed_load = 0, shift_req = 0;
  logic [1:0] code = 0;
  logic [W-1:0] seed_data = 0;
  logic code_ready, scan_bit, scan_valid, load_done;

  int checks = 0, errors = 0, m_blk = 0;
  logic [W-1:0] m_lfsr = 16'h0001;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blk_fill_expander #(.BLK_LEN(B), .BLKS_PER_LOAD(BPL), .LFSR_W(W), .LFSR_TAPS(TAPS)) u0 (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code), .code_ready(code_ready),
    .seed_load(seed_load), .seed_data(seed_data), .shift_req(shift_req),
    .scan_bit(scan_bit), .scan_valid(scan_valid), .load_done(load_done));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : '0);
  endfunction

  function automatic logic model_bit(input logic [1:0] c);
    logic b;
    if (c[1]) begin b = m_lfsr[0]; m_lfsr = step(m_lfsr); end
    else b = c[0];
    return b;
  endfunction

  function automatic string tag_of(input logic [1:0] c);
    return (c == 2'b00) ? "R2" : (c == 2'b01) ? "R3" : "R4";
  endfunction

  task automatic emit_bits(input logic [1:0] c, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check("R7 valid", scan_valid, 1);
      check(tag, scan_bit, model_bit(c));
      check("R9 done", load_done, (i == n - 1 && (m_blk % BPL) == BPL - 1));
    end
    m_blk++;
  endtask

  task automatic run_block(input logic [1:0] c, input string tag);
    @(negedge clk);
    code_valid = 1; code = c; shift_req = 0;
    check("R8 ready idle", code_ready, 1);
    @(posedge clk); @(negedge clk);
    code_valid = 0; shift_req = 1;
    emit_bits(c, B, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid", scan_valid, 0);
    check("R1 done", load_done, 0);
    check("R1 ready", code_ready, 1);

    // Table walk: R1 init seed, R5 constant blocks leave the sequence untouched
    for (int v = 0; v < NV; v++) run_block(CODES[v], tag_of(CODES[v]));

    // R7: request with no block in progress
    @(negedge clk); shift_req = 1;
    @(posedge clk); @(negedge clk);
    check("R7 idle", scan_valid, 0);
    shift_req = 0;

    // R6: seed reload restarts the sequence
    @(negedge clk); seed_load = 1; seed_data = 16'hACE1;
    @(negedge clk); seed_load = 0; m_lfsr = 16'hACE1;
    run_block(2'b10, "R6");
    run_block(2'b11, "R6");

    // R8: next code taken on the final bit, no gap
    @(negedge clk); code_valid = 1; code = 2'b01; shift_req = 0;
    @(posedge clk); @(negedge clk);
    code_valid = 0; shift_req = 1;
    check("R8 busy", code_ready, 0);
    for (int i = 0; i < B - 1; i++) begin
      @(posedge clk); @(negedge clk);
      check("R3", scan_bit, model_bit(2'b01));
    end
    code_valid = 1; code = 2'b00;
    check("R8 last", code_ready, 1);
    @(posedge clk); @(negedge clk);
    code_valid = 0;
    check("R3", scan_bit, model_bit(2'b01));
    check("R9 done", load_done, (m_blk % BPL) == BPL - 1);
    m_blk++;
    emit_bits(2'b00, B, "R8 back-to-back");
    shift_req = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule